// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor built as a microcode engine. A 64-word control store holds wide microinstruction words. The word being executed sits in a microinstruction register, and its control field drives the datapath control-signal outputs directly. Because the outputs come from a register, they hold steady for the whole clock cycle. The main work of the block is sequencing: it chooses the next microaddress on every rising clock edge.

Each word names a next-address source and a one-hot condition test on the N and Z condition-code inputs. There are four sources: the incremented microaddress, a start address looked up from the macro opcode, an externally supplied address, and the word's own branch field. When the test passes, the selected source is loaded. When the test fails, or when the word sets no condition bit, the microaddress simply increments. Two requests override ordinary sequencing: a synchronous reset forces microaddress 0, and an exception request loads the external address. Reset wins over an exception.

The control-store program works as follows. A shared fetch routine runs at 0, 1 and 2, and word 2 dispatches on the opcode. Each instruction routine returns to 0 with an unconditional branch. On each cycle the sequencer takes one of six decisions: RESET, EXCEPTION, INCREMENT, DISPATCH, EXTERNAL or BRANCH.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next microaddress is 0 and `ctrl_out` becomes the first fetch word, which has only control bit 0 set.
- R2: Fetch runs at microaddresses 0→1→2, with control bits 0, 1 and 2 set in turn. Word 2 dispatches unconditionally on `opcode`: 0→8, 1→16, 2→24, 3→32, and every other value →40. Routine 40 sets control bit 15 and then returns.
- R3: A word is laid out as {select[1:0], cond[4:0], control[15:0], branch[5:0]}, with select in the most significant bits. The select codes are: 00 incremented address, 01 opcode start address, 10 `ext_addr`, 11 branch field. Routine 24 sets control bit 10 and uses select 10 with the Z test. When Z=1 it goes to `ext_addr`; otherwise it goes to 25, which sets bit 11.
- R4: The condition bits are one-hot: bit 4 unconditional, bit 3 not-N, bit 2 N, bit 1 not-Z, bit 0 Z. A failed test loads the incremented address. Word 32 sets bit 12 and loops on itself while Z=0. Word 33 branches to 36 (bit 14) while N=0, and otherwise goes to 34 (bit 13).
- R5: A word with no condition bit set always increments, whatever its select field holds. Routine 8 runs 8 (bit 4) → 9 (bit 5, branch select, no condition) → 10 (bit 6).
- R6: A test-only word drives an all-zero control output. Word 16 is test-only and branches to 20 (bit 9) when N=1, and otherwise goes to 17 (bit 8). Word 33 is also test-only.
- R7: With `rst` low, `exc_req` loads `ext_addr` at the next edge, ahead of any sequencing. Reset takes priority over an exception. Word 48 sets bit 3 and then returns.
- R8: The last word of every routine is an unconditional branch back to microaddress 0.
- R9: Words not listed above are all zero. Incrementing from 63 wraps the microaddress to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset request, active high |
| opcode | input | 3 | Macro-instruction opcode used for dispatch |
| flag_n | input | 1 | N condition code |
| flag_z | input | 1 | Z condition code |
| ext_addr | input | 6 | Externally supplied microaddress |
| exc_req | input | 1 | Synchronous exception request |
| ctrl_out | output | 16 | Datapath control signals from the registered word |
| uaddr | output | 6 | Current microaddress |

## Verification
Every opcode class is run through fetch and dispatch. The undefined opcodes show whether the default start address is used. The N routine is run with N set and with N clear, and the Z-to-external routine with Z set and with Z clear. Together these separate a taken branch from the fall-back increment, and the branch field from the external source. The loop routine is run with Z held low for several cycles and then with N toggled, which exercises the inverted tests. Exception requests are applied mid-routine, alone and together with reset, to check priority. Another exception request targets address 62 to exercise the wrap from 63.

// File: rtl/useq_pkg.sv
package useq_pkg;
    parameter int UA_W   = 6;
    parameter int CTRL_W = 16;
    parameter int OPC_W  = 3;
    parameter int COND_W = 5;
    parameter int SEL_W  = 2;
    localparam int DEPTH  = 1 << UA_W;
    localparam int WORD_W = SEL_W + COND_W + CTRL_W + UA_W;

    // condition bit positions
    localparam int C_UNC = 4;
    localparam int C_NN  = 3;
    localparam int C_N   = 2;
    localparam int C_NZ  = 1;
    localparam int C_Z   = 0;

    localparam logic [COND_W-1:0] CND_NONE = 5'b00000;
    localparam logic [COND_W-1:0] CND_UNC  = 5'b10000;
    localparam logic [COND_W-1:0] CND_NN   = 5'b01000;
    localparam logic [COND_W-1:0] CND_N    = 5'b00100;
    localparam logic [COND_W-1:0] CND_NZ   = 5'b00010;
    localparam logic [COND_W-1:0] CND_Z    = 5'b00001;

    // routine entry points
    localparam int A_FETCH = 0;
    localparam int A_ADD   = 8;
    localparam int A_TSTN  = 16;
    localparam int A_EXTZ  = 24;
    localparam int A_LOOP  = 32;
    localparam int A_BAD   = 40;
    localparam int A_TRAP  = 48;

    typedef enum logic [SEL_W-1:0] {
        SEL_INC  = 2'b00,
        SEL_DISP = 2'b01,
        SEL_EXT  = 2'b10,
        SEL_BR   = 2'b11
    } sel_e;

    typedef enum logic [2:0] {
        NS_RESET,
        NS_EXC,
        NS_INC,
        NS_DISP,
        NS_EXT,
        NS_BRANCH
    } nxt_src_e;

    typedef struct packed {
        sel_e               sel;
        logic [COND_W-1:0]  cond;
        logic [CTRL_W-1:0]  ctrl;
        logic [UA_W-1:0]    baddr;
    } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    function automatic uword_t mk(sel_e s, logic [COND_W-1:0] c, int bitn, int ba);
        uword_t w;
        w.sel   = s;
        w.cond  = c;
        w.ctrl  = (bitn < 0) ? '0 : (CTRL_W'(1) << bitn);
        w.baddr = UA_W'(ba);
        return w;
    endfunction

    always_comb begin
        case (int'(addr))
            0:  word = mk(SEL_INC,  CND_NONE, 0,  0);
            1:  word = mk(SEL_INC,  CND_NONE, 1,  0);
            2:  word = mk(SEL_DISP, CND_UNC,  2,  0);
            8:  word = mk(SEL_INC,  CND_NONE, 4,  0);
            9:  word = mk(SEL_BR,   CND_NONE, 5,  50);
            10: word = mk(SEL_BR,   CND_UNC,  6,  A_FETCH);
            16: word = mk(SEL_BR,   CND_N,    -1, 20);
            17: word = mk(SEL_BR,   CND_UNC,  8,  A_FETCH);
            20: word = mk(SEL_BR,   CND_UNC,  9,  A_FETCH);
            24: word = mk(SEL_EXT,  CND_Z,    10, 0);
            25: word = mk(SEL_BR,   CND_UNC,  11, A_FETCH);
            32: word = mk(SEL_BR,   CND_NZ,   12, A_LOOP);
            33: word = mk(SEL_BR,   CND_NN,   -1, 36);
            34: word = mk(SEL_BR,   CND_UNC,  13, A_FETCH);
            36: word = mk(SEL_BR,   CND_UNC,  14, A_FETCH);
            40: word = mk(SEL_BR,   CND_UNC,  15, A_FETCH);
            48: word = mk(SEL_BR,   CND_UNC,  3,  A_FETCH);
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UA_W-1:0]  start
);
    always_comb begin
        case (int'(opcode))
            0:       start = UA_W'(A_ADD);
            1:       start = UA_W'(A_TSTN);
            2:       start = UA_W'(A_EXTZ);
            3:       start = UA_W'(A_LOOP);
            default: start = UA_W'(A_BAD);
        endcase
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  logic              rst,
    input  logic              exc_req,
    input  logic              flag_n,
    input  logic              flag_z,
    input  sel_e              sel,
    input  logic [COND_W-1:0] cond,
    input  logic [UA_W-1:0]   baddr,
    input  logic [UA_W-1:0]   upc,
    input  logic [UA_W-1:0]   start,
    input  logic [UA_W-1:0]   ext_addr,
    output nxt_src_e          src,
    output logic [UA_W-1:0]   nxt
);
    logic [COND_W-1:0] met;
    logic              taken;

    always_comb begin
        met          = '0;
        met[C_UNC]   = 1'b1;
        met[C_NN]    = ~flag_n;
        met[C_N]     = flag_n;
        met[C_NZ]    = ~flag_z;
        met[C_Z]     = flag_z;
        taken        = |(cond & met);
    end

    // decision process
    always_comb begin
        if (rst) begin
            src = NS_RESET;
        end else if (exc_req) begin
            src = NS_EXC;
        end else if (!taken) begin
            src = NS_INC;
        end else begin
            unique case (sel)
                SEL_INC:  src = NS_INC;
                SEL_DISP: src = NS_DISP;
                SEL_EXT:  src = NS_EXT;
                SEL_BR:   src = NS_BRANCH;
            endcase
        end
    end

    // address process
    always_comb begin
        unique case (src)
            NS_RESET:  nxt = UA_W'(A_FETCH);
            NS_EXC:    nxt = ext_addr;
            NS_INC:    nxt = upc + UA_W'(1);
            NS_DISP:   nxt = start;
            NS_EXT:    nxt = ext_addr;
            NS_BRANCH: nxt = baddr;
            default:   nxt = UA_W'(A_FETCH);
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [UA_W-1:0]   ext_addr,
    input  logic              exc_req,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [UA_W-1:0]   uaddr
);
    logic [UA_W-1:0]   upc_q;
    uword_t            uir_q;
    uword_t            rd_word;
    logic [UA_W-1:0]   nxt;
    logic [UA_W-1:0]   start;
    nxt_src_e          src;
    sel_e              cur_sel;
    logic [COND_W-1:0] cur_cond;
    logic [UA_W-1:0]   cur_baddr;

    assign cur_sel   = uir_q.sel;
    assign cur_cond  = uir_q.cond;
    assign cur_baddr = uir_q.baddr;

    useq_dispatch i_disp (
        .opcode (opcode),
        .start  (start)
    );

    useq_next i_next (
        .rst      (rst),
        .exc_req  (exc_req),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .sel      (cur_sel),
        .cond     (cur_cond),
        .baddr    (cur_baddr),
        .upc      (upc_q),
        .start    (start),
        .ext_addr (ext_addr),
        .src      (src),
        .nxt      (nxt)
    );

    useq_store i_store (
        .addr (nxt),
        .word (rd_word)
    );

    // state register: microaddress and microinstruction move together
    always_ff @(posedge clk) begin
        upc_q <= nxt;
        uir_q <= rd_word;
    end

    // outputs
    always_comb begin
        uaddr    = upc_q;
        ctrl_out = uir_q.ctrl;
    end
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exc_req,
    input logic [UA_W-1:0]   ext_addr,
    input logic [UA_W-1:0]   uaddr,
    input logic [SEL_W-1:0]  cur_sel,
    input logic [COND_W-1:0] cur_cond,
    input logic [UA_W-1:0]   cur_baddr
);
    // R1
    reset_fetch_chk: assert property (@(posedge clk)
        rst |=> (uaddr == UA_W'(A_FETCH)));

    // R7
    exc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |=> (uaddr == $past(ext_addr)));

    // R5
    no_cond_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && cur_cond == '0) |=> (uaddr == $past(uaddr) + UA_W'(1)));

    // R4
    cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cur_cond));

    // R8
    uncond_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && cur_cond[C_UNC] && cur_sel == SEL_BR)
        |=> (uaddr == $past(cur_baddr)));

    // R2
    dispatch_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!exc_req && cur_cond[C_UNC] && cur_sel == SEL_DISP)
        |=> (uaddr inside {UA_W'(A_ADD), UA_W'(A_TSTN), UA_W'(A_EXTZ),
                           UA_W'(A_LOOP), UA_W'(A_BAD)}));
endmodule

bind useq_ctrl useq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .exc_req   (exc_req),
    .ext_addr  (ext_addr),
    .uaddr     (uaddr),
    .cur_sel   (cur_sel),
    .cur_cond  (cur_cond),
    .cur_baddr (cur_baddr)
);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  opcode = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic [5:0]  ext_addr = '0;
    logic        exc_req = 1'b0;
    logic [15:0] ctrl_out;
    logic [5:0]  uaddr;

    int checks = 0;
    int errors = 0;
    int m_pc   = 0;

    always #(CLK_T/2) clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .flag_n   (flag_n),
        .flag_z   (flag_z),
        .ext_addr (ext_addr),
        .exc_req  (exc_req),
        .ctrl_out (ctrl_out),
        .uaddr    (uaddr)
    );

    // Behavioural program description from the brief.
    // sel: 0 inc, 1 opcode start, 2 external, 3 branch field
    // cnd: 0 none, 1 always, 2 not-N, 3 N, 4 not-Z, 5 Z
    function automatic void ref_word(input int a, output int sel, output int cnd,
                                     output int cb, output int ba);
        sel = 0; cnd = 0; cb = -1; ba = 0;
        case (a)
            0:  cb = 0;
            1:  cb = 1;
            2:  begin sel = 1; cnd = 1; cb = 2; end
            8:  cb = 4;
            9:  begin sel = 3; cb = 5; ba = 50; end
            10: begin sel = 3; cnd = 1; cb = 6; end
            16: begin sel = 3; cnd = 3; ba = 20; end
            17: begin sel = 3; cnd = 1; cb = 8; end
            20: begin sel = 3; cnd = 1; cb = 9; end
            24: begin sel = 2; cnd = 5; cb = 10; end
            25: begin sel = 3; cnd = 1; cb = 11; end
            32: begin sel = 3; cnd = 4; cb = 12; ba = 32; end
            33: begin sel = 3; cnd = 2; ba = 36; end
            34: begin sel = 3; cnd = 1; cb = 13; end
            36: begin sel = 3; cnd = 1; cb = 14; end
            40: begin sel = 3; cnd = 1; cb = 15; end
            48: begin sel = 3; cnd = 1; cb = 3; end
            default: ;
        endcase
    endfunction

    function automatic int start_of(input int opc);
        case (opc)
            0: return 8;
            1: return 16;
            2: return 24;
            3: return 32;
            default: return 40;
        endcase
    endfunction

    task automatic step(input int opc, input bit n, input bit z, input int ext,
                        input bit exc, input bit r, input string tag);
        int sel, cnd, cb, ba;
        bit take;
        logic [15:0] exp_ctrl;
        opcode = 3'(opc); flag_n = n; flag_z = z;
        ext_addr = 6'(ext); exc_req = exc; rst = r;
        @(posedge clk);
        if (r) m_pc = 0;
        else if (exc) m_pc = ext;
        else begin
            ref_word(m_pc, sel, cnd, cb, ba);
            take = (cnd == 1) || (cnd == 2 && !n) || (cnd == 3 && n)
                || (cnd == 4 && !z) || (cnd == 5 && z);
            if (!take) m_pc = (m_pc + 1) % 64;
            else case (sel)
                0: m_pc = (m_pc + 1) % 64;
                1: m_pc = start_of(opc);
                2: m_pc = ext;
                default: m_pc = ba;
            endcase
        end
        ref_word(m_pc, sel, cnd, cb, ba);
        exp_ctrl = (cb < 0) ? 16'h0 : (16'h1 << cb);
        #(CLK_T/4);
        checks++;
        if (uaddr !== 6'(m_pc) || ctrl_out !== exp_ctrl) begin
            errors++;
            $display("FAIL %s: uaddr=%0d exp %0d, ctrl=%h exp %h",
                     tag, uaddr, m_pc, ctrl_out, exp_ctrl);
        end
    endtask

    task automatic run(input int opc, input bit n, input bit z, input int ext,
                       input int cyc, input string tag);
        for (int i = 0; i < cyc; i++) step(opc, n, z, ext, 1'b0, 1'b0, tag);
    endtask

    initial begin
        step(0, 0, 0, 0, 0, 1, "R1");
        step(0, 0, 0, 0, 0, 1, "R1");
        run(0, 0, 0, 0, 6, "R5");      // 1,2,8,9,10,0
        run(1, 1, 0, 0, 5, "R6");      // 1,2,16,20,0
        run(1, 0, 0, 0, 5, "R6");      // 1,2,16,17,0
        run(2, 0, 1, 48, 5, "R3");     // 1,2,24,48,0
        run(2, 0, 0, 48, 5, "R3");     // 1,2,24,25,0
        run(3, 0, 0, 0, 5, "R4");      // 1,2,32,32,32
        run(3, 0, 1, 0, 1, "R4");      // 33
        run(3, 0, 1, 0, 2, "R4");      // 36,0
        run(3, 1, 0, 0, 3, "R4");      // 1,2,32
        run(3, 1, 1, 0, 3, "R8");      // 33,34,0
        run(5, 0, 0, 0, 4, "R2");      // 1,2,40,0
        run(7, 0, 0, 0, 4, "R2");
        run(0, 0, 0, 0, 3, "R2");      // 1,2,8
        step(0, 0, 0, 48, 1, 0, "R7"); // 48
        run(0, 0, 0, 0, 1, "R8");      // 0
        run(1, 0, 0, 0, 2, "R7");      // 1,2
        step(0, 0, 0, 48, 1, 1, "R7"); // reset wins: 0
        step(0, 0, 0, 62, 1, 0, "R9"); // 62
        run(0, 0, 0, 0, 2, "R9");      // 63,0
        step(0, 0, 0, 0, 0, 1, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_T * 5000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule